// File: doc/BRIEF.md
# Vector Slice Issue Sequencer

The sequencer walks one vector instruction through a pipe in which every vector register is split into a fixed number of slices. When an instruction is accepted, its descriptor is latched. The sequencer then presents one slice token per cycle. A token names the register slices that the slot reads and writes, flags scalar operand traffic, and gives the element window of any memory access.

A token holds still until the external scoreboard raises `opReady` for it. Each slot therefore waits only on its own operands, which gives chaining against earlier instructions. A widening instruction doubles the footprint of the destination and of the wide source. Its narrow source is then interleaved with empty slots.

A new instruction is accepted only when no slot of the previous one is still pending.

Top module: `vsliceSeq`

## Requirements
- R1: After reset, `issueReady` is 1 and `slotValid` is 0.
- R2: An instruction is accepted on a clock edge where `issueValid` and `issueReady` are both 1. The first token (index 0) is presented in the following cycle. While tokens are pending, `issueReady` is 0 and `issueValid` and the descriptor inputs have no effect on the tokens.
- R3: The LMUL code is 3 bits. Codes 0 to 3 mean 1, 2, 4 and 8. Codes 5, 6 and 7 mean 1/8, 1/4 and 1/2. Code 4 is taken as 1.
- R4: The slot count is 2^max(0, L + e), where S = 2^L is the slices per register and e is log2 of the LMUL, plus 1 when `inWiden` is 1. The count is never below 1.
- R5: Token indices run from 0 to count−1 in order. A token advances on each edge where `opReady` is 1. With `opReady` at 0, the token and all its fields hold.
- R6: For a full-footprint operand at slot j, the register is base + (j >> L) modulo 32 and the slice is j mod S. This applies to `vd` and `vs2` always, and to `vs1` when not widening.
- R7: When widening, `vs1` is real only on even slots, with `vs1Valid` 1 there and 0 on odd slots. On an even slot j it addresses narrow position j/2, using the mapping of R6.
- R8: `scalarRead` is 1 only on slot 0, and only if `inScalarSrc` was set. `scalarWrite` is 1 only on the last slot, and only if `inScalarDst` was set.
- R9: The slot width is n >> log2(count), where n is the element count. Slot j starts at j × that width, and `memCount` is the width clipped to the elements that remain.
- R10: `lastSlot` is 1 exactly on slot count−1. On the edge where that slot is taken, the sequencer goes idle and `issueReady` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Descriptor offered |
| issueReady | output | 1 | Sequencer idle, can accept |
| inVd | input | REG_W | Destination base register |
| inVs1 | input | REG_W | First source base register (narrow when widening) |
| inVs2 | input | REG_W | Second source base register (wide when widening) |
| inLmul | input | 3 | LMUL code |
| inWiden | input | 1 | Widening instruction |
| inScalarSrc | input | 1 | Instruction reads a scalar register |
| inScalarDst | input | 1 | Instruction writes a scalar register |
| inElemCount | input | ELEM_W | Memory element count n |
| opReady | input | 1 | Operands of the presented slot are ready |
| slotValid | output | 1 | A token is presented |
| slotIndex | output | SLICE_LOG+5 | Slot number within the instruction |
| lastSlot | output | 1 | Presented slot is the final one |
| vs1Valid | output | 1 | vs1 slice is read in this slot |
| vs1Reg | output | REG_W | vs1 register of this slot |
| vs1Slice | output | SLICE_LOG | vs1 slice of this slot |
| vs2Reg | output | REG_W | vs2 register of this slot |
| vs2Slice | output | SLICE_LOG | vs2 slice of this slot |
| vdReg | output | REG_W | Destination register of this slot |
| vdSlice | output | SLICE_LOG | Destination slice of this slot |
| scalarRead | output | 1 | Scalar source read in this slot |
| scalarWrite | output | 1 | Scalar destination written in this slot |
| memStart | output | ELEM_W | First element of this slot |
| memCount | output | ELEM_W | Elements handled by this slot |

## Verification
A wrong slot counter, or a wrong latched descriptor, shows up on the very first token after acceptance as a bad register, slice or element window. A wrong slot-count decode shows up as `lastSlot` arriving early or late. That error is visible within one instruction, or at the latest when `issueReady` returns. A counter that moves under a stall, or a descriptor overwritten while busy, changes the presented fields in the cycle right after the stray edge. The bench therefore compares every field of every cycle against a model.

// File: rtl/vsliceSeqPkg.sv
package vsliceSeqPkg;

  typedef struct packed {
    logic load;   // capture descriptor, start at slot 0
    logic step;   // advance to next slot
    logic done;   // final slot taken, go idle
  } seqStrobeT;

  // log2 of the LMUL code; code 4 is treated as LMUL 1
  function automatic int lmulLog(input logic [2:0] code);
    int r;
    case (code)
      3'd0: r = 0;
      3'd1: r = 1;
      3'd2: r = 2;
      3'd3: r = 3;
      3'd5: r = -3;
      3'd6: r = -2;
      3'd7: r = -1;
      default: r = 0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vsliceSeqCtrl.sv
module vsliceSeqCtrl
  import vsliceSeqPkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             opReady,
  input  logic             isLast,
  output seqStrobeT        strb,
  output logic             busy,
  output logic [CNT_W-1:0] idx
);

  always_comb begin
    strb.load = issueValid & ~busy;
    strb.step = busy & opReady & ~isLast;
    strb.done = busy & opReady & isLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (strb.load) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (strb.step) begin
      idx  <= idx + 1'b1;
    end else if (strb.done) begin
      busy <= 1'b0;
      idx  <= '0;
    end
  end

endmodule

// File: rtl/vsliceSeqDatapath.sv
module vsliceSeqDatapath
  import vsliceSeqPkg::*;
#(
  parameter int SLICE_LOG = 2,
  parameter int REG_W     = 5,
  parameter int ELEM_W    = 10,
  parameter int CNT_W     = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobeT            strb,
  input  logic [REG_W-1:0]     inVd,
  input  logic [REG_W-1:0]     inVs1,
  input  logic [REG_W-1:0]     inVs2,
  input  logic [2:0]           inLmul,
  input  logic                 inWiden,
  input  logic                 inScalarSrc,
  input  logic                 inScalarDst,
  input  logic [ELEM_W-1:0]    inElemCount,
  input  logic [CNT_W-1:0]     idx,
  output logic                 isLast,
  output logic                 vs1Valid,
  output logic [REG_W-1:0]     vs1Reg,
  output logic [SLICE_LOG-1:0] vs1Slice,
  output logic [REG_W-1:0]     vs2Reg,
  output logic [SLICE_LOG-1:0] vs2Slice,
  output logic [REG_W-1:0]     vdReg,
  output logic [SLICE_LOG-1:0] vdSlice,
  output logic                 scalarRead,
  output logic                 scalarWrite,
  output logic [ELEM_W-1:0]    memStart,
  output logic [ELEM_W-1:0]    memCount
);

  localparam int PROD_W = ELEM_W + CNT_W;

  logic [REG_W-1:0]  dVd, dVs1, dVs2;
  logic [2:0]        dLmul;
  logic              dWiden, dSs, dSd;
  logic [ELEM_W-1:0] dN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dVd <= '0; dVs1 <= '0; dVs2 <= '0; dLmul <= '0;
      dWiden <= 1'b0; dSs <= 1'b0; dSd <= 1'b0; dN <= '0;
    end else if (strb.load) begin
      dVd <= inVd; dVs1 <= inVs1; dVs2 <= inVs2; dLmul <= inLmul;
      dWiden <= inWiden; dSs <= inScalarSrc; dSd <= inScalarDst;
      dN <= inElemCount;
    end
  end

  int                cLog;
  logic [CNT_W-1:0]  total;
  logic [CNT_W-1:0]  narrowIdx;
  logic [ELEM_W-1:0] sliceLen;
  logic [PROD_W-1:0] startWide;
  logic [ELEM_W-1:0] remain;

  always_comb begin
    cLog = SLICE_LOG + lmulLog(dLmul) + (dWiden ? 1 : 0);
    if (cLog < 0) cLog = 0;
    total  = CNT_W'(1) << cLog;
    isLast = (idx == total - 1'b1);

    vdReg    = dVd  + REG_W'(idx >> SLICE_LOG);
    vdSlice  = idx[SLICE_LOG-1:0];
    vs2Reg   = dVs2 + REG_W'(idx >> SLICE_LOG);
    vs2Slice = idx[SLICE_LOG-1:0];

    narrowIdx = dWiden ? (idx >> 1) : idx;
    vs1Valid  = dWiden ? ~idx[0] : 1'b1;
    vs1Reg    = dVs1 + REG_W'(narrowIdx >> SLICE_LOG);
    vs1Slice  = narrowIdx[SLICE_LOG-1:0];

    scalarRead  = dSs & (idx == '0);
    scalarWrite = dSd & isLast;

    sliceLen  = dN >> cLog;
    startWide = PROD_W'(idx) * PROD_W'(sliceLen);
    memStart  = ELEM_W'(startWide);
    remain    = dN - memStart;
    memCount  = (sliceLen < remain) ? sliceLen : remain;
  end

endmodule

// File: rtl/vsliceSeq.sv
module vsliceSeq
  import vsliceSeqPkg::*;
#(
  parameter int SLICE_LOG = 2,
  parameter int REG_W     = 5,
  parameter int ELEM_W    = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   issueValid,
  output logic                   issueReady,
  input  logic [REG_W-1:0]       inVd,
  input  logic [REG_W-1:0]       inVs1,
  input  logic [REG_W-1:0]       inVs2,
  input  logic [2:0]             inLmul,
  input  logic                   inWiden,
  input  logic                   inScalarSrc,
  input  logic                   inScalarDst,
  input  logic [ELEM_W-1:0]      inElemCount,
  input  logic                   opReady,
  output logic                   slotValid,
  output logic [SLICE_LOG+4:0]   slotIndex,
  output logic                   lastSlot,
  output logic                   vs1Valid,
  output logic [REG_W-1:0]       vs1Reg,
  output logic [SLICE_LOG-1:0]   vs1Slice,
  output logic [REG_W-1:0]       vs2Reg,
  output logic [SLICE_LOG-1:0]   vs2Slice,
  output logic [REG_W-1:0]       vdReg,
  output logic [SLICE_LOG-1:0]   vdSlice,
  output logic                   scalarRead,
  output logic                   scalarWrite,
  output logic [ELEM_W-1:0]      memStart,
  output logic [ELEM_W-1:0]      memCount
);

  localparam int CNT_W = SLICE_LOG + 5;

  seqStrobeT        strb;
  logic             busy, isLast, dpV1, dpSr, dpSw;
  logic [CNT_W-1:0] idx;

  vsliceSeqCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opReady(opReady),
    .isLast(isLast), .strb(strb), .busy(busy), .idx(idx)
  );

  vsliceSeqDatapath #(
    .SLICE_LOG(SLICE_LOG), .REG_W(REG_W), .ELEM_W(ELEM_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inVd(inVd), .inVs1(inVs1), .inVs2(inVs2), .inLmul(inLmul),
    .inWiden(inWiden), .inScalarSrc(inScalarSrc), .inScalarDst(inScalarDst),
    .inElemCount(inElemCount), .idx(idx), .isLast(isLast),
    .vs1Valid(dpV1), .vs1Reg(vs1Reg), .vs1Slice(vs1Slice),
    .vs2Reg(vs2Reg), .vs2Slice(vs2Slice), .vdReg(vdReg), .vdSlice(vdSlice),
    .scalarRead(dpSr), .scalarWrite(dpSw),
    .memStart(memStart), .memCount(memCount)
  );

  assign issueReady  = ~busy;
  assign slotValid   = busy;
  assign slotIndex   = idx;
  assign lastSlot    = busy & isLast;
  assign vs1Valid    = busy & dpV1;
  assign scalarRead  = busy & dpSr;
  assign scalarWrite = busy & dpSw;

endmodule

// File: rtl/vsliceSeqChecker.sv
module vsliceSeqChecker #(
  parameter int SLICE_LOG = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 issueValid,
  input logic                 issueReady,
  input logic                 opReady,
  input logic                 slotValid,
  input logic [SLICE_LOG+4:0] slotIndex,
  input logic                 lastSlot,
  input logic                 scalarRead,
  input logic                 scalarWrite
);

  AST_IDLE_NO_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    issueReady |-> !slotValid); // R2
  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && issueReady |=> slotValid && slotIndex == '0); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    slotValid && !opReady |=> slotValid && $stable(slotIndex)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    slotValid && opReady && !lastSlot |=> slotValid && slotIndex == $past(slotIndex) + 1'b1); // R5
  AST_SCALAR_READ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    scalarRead |-> slotValid && slotIndex == '0); // R8
  AST_SCALAR_WRITE_LAST: assert property (@(posedge clk) disable iff (!rstN)
    scalarWrite |-> lastSlot); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    slotValid && opReady && lastSlot |=> issueReady); // R10

endmodule

bind vsliceSeq vsliceSeqChecker #(.SLICE_LOG(SLICE_LOG)) u_vsliceSeqChecker (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
  .opReady(opReady), .slotValid(slotValid), .slotIndex(slotIndex),
  .lastSlot(lastSlot), .scalarRead(scalarRead), .scalarWrite(scalarWrite)
);

// File: tb/vsliceSeq_bench.sv
`timescale 1ns/1ps
module vsliceSeq_bench;
  localparam int SL = 2;
  localparam int RW = 5;
  localparam int EW = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic issueValid = 1'b0, opReady = 1'b0;
  logic [RW-1:0] inVd = '0, inVs1 = '0, inVs2 = '0;
  logic [2:0] inLmul = '0;
  logic inWiden = 1'b0, inScalarSrc = 1'b0, inScalarDst = 1'b0;
  logic [EW-1:0] inElemCount = '0;
  logic issueReady, slotValid, lastSlot, vs1Valid, scalarRead, scalarWrite;
  logic [SL+4:0] slotIndex;
  logic [RW-1:0] vs1Reg, vs2Reg, vdReg;
  logic [SL-1:0] vs1Slice, vs2Slice, vdSlice;
  logic [EW-1:0] memStart, memCount;

  int checks = 0, errors = 0, cycles = 0;

  vsliceSeq #(.SLICE_LOG(SL), .REG_W(RW), .ELEM_W(EW)) u_vsliceSeq (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cLogOf(input int lm, input bit w);
    int e, c;
    e = (lm < 4) ? lm : ((lm == 4) ? 0 : lm - 8);   // R3
    c = SL + e + (w ? 1 : 0);
    return (c < 0) ? 0 : c;                          // R4
  endfunction

  task automatic runInstr(input int vd, input int v1, input int v2, input int lm,
                          input bit w, input bit ss, input bit sd, input int n,
                          input int readyPct);
    int c, tot, j, len, st, rem, nj;
    c = cLogOf(lm, w);
    tot = 1 << c;
    len = n >> c;
    @(negedge clk);
    chk(issueReady === 1'b1, "R10 idle before issue", int'(issueReady), 1);
    issueValid = 1'b1; inVd = RW'(vd); inVs1 = RW'(v1); inVs2 = RW'(v2);
    inLmul = 3'(lm); inWiden = w; inScalarSrc = ss; inScalarDst = sd;
    inElemCount = EW'(n);
    j = 0;
    @(negedge clk);
    while (j < tot) begin
      // R2: stray offers while busy must not disturb the token stream
      issueValid = ($urandom % 4 == 0);
      inVd = RW'($urandom); inVs1 = RW'($urandom); inVs2 = RW'($urandom);
      inLmul = 3'($urandom); inWiden = 1'($urandom); inElemCount = EW'($urandom);
      opReady = (($urandom % 100) < readyPct);
      chk(slotValid === 1'b1 && issueReady === 1'b0, "R2 busy", int'(slotValid), 1);
      chk(slotIndex == j, "R5 index", int'(slotIndex), j);
      chk(lastSlot == (j == tot - 1), "R10 lastSlot", int'(lastSlot), int'(j == tot - 1));
      chk(vdReg == RW'(vd + (j >> SL)) && vdSlice == SL'(j), "R6 vd",
          int'(vdReg) * 16 + int'(vdSlice), ((vd + (j >> SL)) % 32) * 16 + (j % (1 << SL)));
      chk(vs2Reg == RW'(v2 + (j >> SL)) && vs2Slice == SL'(j), "R6 vs2",
          int'(vs2Reg), (v2 + (j >> SL)) % 32);
      nj = w ? (j >> 1) : j;
      chk(vs1Valid == (w ? (j % 2 == 0) : 1'b1), "R7 vs1Valid", int'(vs1Valid), int'(!w || j % 2 == 0));
      if (!w || j % 2 == 0)
        chk(vs1Reg == RW'(v1 + (nj >> SL)) && vs1Slice == SL'(nj), "R7 vs1 slot",
            int'(vs1Reg) * 16 + int'(vs1Slice), ((v1 + (nj >> SL)) % 32) * 16 + (nj % (1 << SL)));
      chk(scalarRead == (ss && j == 0), "R8 scalarRead", int'(scalarRead), int'(ss && j == 0));
      chk(scalarWrite == (sd && j == tot - 1), "R8 scalarWrite", int'(scalarWrite), int'(sd && j == tot - 1));
      st = (j * len) % (1 << EW);
      rem = n - st;
      chk(memStart == EW'(st), "R9 memStart", int'(memStart), st);
      chk(memCount == EW'((len < rem) ? len : rem), "R9 memCount", int'(memCount), (len < rem) ? len : rem);
      @(negedge clk);
      if (opReady) j++;
    end
    issueValid = 1'b0; opReady = 1'b0;
    chk(issueReady === 1'b1 && slotValid === 1'b0, "R10 release", int'(issueReady), 1);
    chk(tot == (1 << cLogOf(lm, w)), "R4 count", tot, 1 << c);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(issueReady === 1'b1, "R1 issueReady", int'(issueReady), 1);
    chk(slotValid === 1'b0, "R1 slotValid", int'(slotValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(issueReady === 1'b1 && slotValid === 1'b0, "R1 after release", int'(slotValid), 0);
    // directed corners: R3 codes, R4 floor, R6 wrap, R7 widening, R8 scalars
    runInstr(0, 8, 16, 0, 0, 1, 1, 64, 100);
    runInstr(30, 4, 28, 3, 0, 0, 1, 100, 60);   // group wraps past 31
    runInstr(2, 5, 6, 5, 0, 1, 1, 7, 50);       // LMUL 1/8: single slot
    runInstr(3, 7, 9, 7, 1, 1, 0, 3, 80);       // 1/2 widened
    runInstr(10, 1, 12, 4, 0, 0, 0, 40, 100);   // reserved code as 1
    runInstr(0, 2, 4, 3, 1, 1, 1, 1000, 90);    // max slots
    runInstr(1, 2, 3, 2, 1, 0, 1, 5, 30);       // fewer elements than slots
    for (int k = 0; k < 40; k++)
      runInstr($urandom % 32, $urandom % 32, $urandom % 32, $urandom % 8,
               1'($urandom), 1'($urandom), 1'($urandom), $urandom % 1024,
               30 + $urandom % 71);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule